// File: doc/BRIEF.md
# Three-Level Programming Pulse Classifier

A pin that normally carries an output waveform can also receive programming pulses. Two analog comparators watch this pin. One reports that the pin is above the mid level and the other that it is above the high level. This block turns those two comparator bits into one-cycle strobes for a protocol controller: one strobe for a mid pulse and one for a high pulse. An excursion is a stretch of time in which the pin leaves the low level and then comes back to it. Each excursion produces at most one strobe. The strobe is issued when the pin returns to low.

Supply edges can be slow. A high pulse therefore spends some time in the mid band on its way up and again on its way down. The block classifies each excursion by the highest level it held long enough. The mid-band passage during the edges of a high pulse is never reported as a separate mid pulse. An excursion is discarded as a glitch in two cases: it is shorter than the minimum active time, or it starts before the pin has been low for the minimum gap. Both comparator bits pass through two-flop synchronizers. Every time threshold is a parameter counted in system clock cycles.

Top module: `pulse_classifier`

## Requirements
- R1: While reset is asserted, and after it is released with the pin low, `midEvt` and `highEvt` are 0.
- R2: An accepted excursion in which `aboveHigh` was 1 for fewer than MIN_ACTIVE sampled cycles produces exactly one `midEvt` pulse and no `highEvt`.
- R3: An accepted excursion in which `aboveHigh` was 1 for at least MIN_ACTIVE sampled cycles produces exactly one `highEvt` pulse and no `midEvt`. This holds even when mid-only cycles come before and after the high portion.
- R4: An excursion is active while `aboveMid` or `aboveHigh` is 1. An excursion active for fewer than MIN_ACTIVE cycles produces no strobe. One active for exactly MIN_ACTIVE cycles is accepted.
- R5: An excursion that starts after fewer than MIN_GAP consecutive low cycles (counted since the previous excursion ended, or since reset) produces no strobe. A gap of exactly MIN_GAP cycles is accepted.
- R6: A strobe rises on the third rising clock edge after the pin inputs return low and stays high for exactly one cycle.
- R7: An excursion of any length, however long it stays active, produces no strobe while it is still active and at most one strobe in total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aboveMid | input | 1 | Asynchronous comparator bit: pin above mid level |
| aboveHigh | input | 1 | Asynchronous comparator bit: pin above high level |
| midEvt | output | 1 | One-cycle strobe: a mid pulse was classified |
| highEvt | output | 1 | One-cycle strobe: a high pulse was classified |

## Verification
The bench builds the block with MIN_ACTIVE = 6 and MIN_GAP = 8. With such short thresholds, each decision boundary is only a few cycles from its neighbours: five versus six active cycles, five versus six high cycles, and seven versus eight low-gap cycles. The vector table reaches every one of these boundaries, including high pulses with slow mid-band edges and early-starting excursions. Directed tests check the strobe latency to the exact cycle and check the outputs during reset.

// File: rtl/pulse_pkg.sv
package pulse_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic incAct;
    logic incHigh;
    logic clrExc;
    logic incLow;
    logic clrLow;
  } dpCtrl_t;

  // datapath -> control threshold flags
  typedef struct packed {
    logic actOk;
    logic highOk;
    logic gapOk;
  } dpStat_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_REJECT = 2'd2
  } clsState_t;

endpackage

// File: rtl/pulse_sync.sv
module pulse_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/pulse_dp.sv
module pulse_dp
  import pulse_pkg::*;
#(
  parameter int MIN_ACTIVE = 2000,
  parameter int MIN_GAP    = 2000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  dpCtrl_t ctrl,
  output dpStat_t stat
);

  localparam int ACT_W = $clog2(MIN_ACTIVE + 1);
  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam logic [ACT_W-1:0] ACT_MAX = ACT_W'(MIN_ACTIVE);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(MIN_GAP);

  logic [ACT_W-1:0] actCnt;
  logic [ACT_W-1:0] highCnt;
  logic [GAP_W-1:0] lowCnt;

  // active cycles of the current excursion, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              actCnt <= '0;
    else if (ctrl.clrExc)                    actCnt <= '0;
    else if (ctrl.incAct && actCnt != ACT_MAX) actCnt <= actCnt + 1'b1;
  end

  // high-level cycles of the current excursion, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                highCnt <= '0;
    else if (ctrl.clrExc)                      highCnt <= '0;
    else if (ctrl.incHigh && highCnt != ACT_MAX) highCnt <= highCnt + 1'b1;
  end

  // consecutive low cycles since the last excursion, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              lowCnt <= '0;
    else if (ctrl.clrLow)                    lowCnt <= '0;
    else if (ctrl.incLow && lowCnt != GAP_MAX) lowCnt <= lowCnt + 1'b1;
  end

  assign stat.actOk  = (actCnt  >= ACT_MAX);
  assign stat.highOk = (highCnt >= ACT_MAX);
  assign stat.gapOk  = (lowCnt  >= GAP_MAX);

  // R5
  gap_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lowCnt <= GAP_MAX);

  // R3
  high_in_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    highCnt <= actCnt);

endmodule

// File: rtl/pulse_ctrl.sv
module pulse_ctrl
  import pulse_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sMid,
  input  logic    sHigh,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    midEvt,
  output logic    highEvt
);

  clsState_t state, stateNxt;
  logic      active;
  logic      emitMid, emitHigh;

  assign active = sMid | sHigh;

  always_comb begin
    ctrl.incAct  = active;
    ctrl.incHigh = active & sHigh;
    ctrl.clrExc  = ~active;
    ctrl.incLow  = ~active;
    ctrl.clrLow  = active;
  end

  always_comb begin
    stateNxt = state;
    emitMid  = 1'b0;
    emitHigh = 1'b0;
    unique case (state)
      ST_IDLE: if (active) stateNxt = stat.gapOk ? ST_ACTIVE : ST_REJECT;
      ST_ACTIVE: if (!active) begin
        stateNxt = ST_IDLE;
        if (stat.actOk) begin
          emitHigh = stat.highOk;
          emitMid  = ~stat.highOk;
        end
      end
      ST_REJECT: if (!active) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      midEvt  <= 1'b0;
      highEvt <= 1'b0;
    end else begin
      state   <= stateNxt;
      midEvt  <= emitMid;
      highEvt <= emitHigh;
    end
  end

  // R7
  evt_after_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (midEvt || highEvt) |-> ($past(state) == ST_ACTIVE && state == ST_IDLE));

  // R3
  high_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    highEvt |-> $past(stat.highOk && stat.actOk));

  // R2
  mid_not_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    midEvt |-> $past(!stat.highOk && stat.actOk));

  // R5
  early_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && active && !stat.gapOk) |=> state == ST_REJECT);

  // R6
  single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (midEvt || highEvt) |=> !(midEvt || highEvt));

endmodule

// File: rtl/pulse_classifier.sv
module pulse_classifier
  import pulse_pkg::*;
#(
  parameter int MIN_ACTIVE  = 2000,
  parameter int MIN_GAP     = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic aboveMid,
  input  logic aboveHigh,
  output logic midEvt,
  output logic highEvt
);

  logic [1:0] syncBits;
  dpCtrl_t    ctrl;
  dpStat_t    stat;

  pulse_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn ({aboveHigh, aboveMid}),
    .syncOut (syncBits)
  );

  pulse_dp #(.MIN_ACTIVE(MIN_ACTIVE), .MIN_GAP(MIN_GAP)) i_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .ctrl  (ctrl),
    .stat  (stat)
  );

  pulse_ctrl i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .sMid    (syncBits[0]),
    .sHigh   (syncBits[1]),
    .stat    (stat),
    .ctrl    (ctrl),
    .midEvt  (midEvt),
    .highEvt (highEvt)
  );

endmodule

// File: tb/test_pulse_classifier.sv
`timescale 1ns/1ps
module test_pulse_classifier;

  localparam int MIN_ACT = 6;
  localparam int MIN_GP  = 8;
  localparam int TRAIL   = 4;
  localparam int NVEC    = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic aMid = 1'b0, aHigh = 1'b0;
  logic midEvt, highEvt;
  int checks = 0, errors = 0;
  int midSeen = 0, highSeen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pulse_classifier #(.MIN_ACTIVE(MIN_ACT), .MIN_GAP(MIN_GP)) i_pulse_classifier (
    .clk(clk), .rst_n(rst_n), .aboveMid(aMid), .aboveHigh(aHigh),
    .midEvt(midEvt), .highEvt(highEvt)
  );

  always @(negedge clk) begin
    if (midEvt)  midSeen++;
    if (highEvt) highSeen++;
  end

  // low gap, mid-only rise, high, mid-only fall, expected (0 none, 1 mid, 2 high)
  // effective gap = low + TRAIL
  typedef struct packed { int low; int rise; int high; int fall; int exp; } vec_t;
  localparam vec_t VECS [NVEC] = '{
    '{20, 6, 0, 0, 1},   // R4 exactly MIN_ACTIVE -> mid (R2)
    '{10, 5, 0, 0, 0},   // R4 one short
    '{10, 3, 6, 3, 2},   // R3 slow edges
    '{10, 3, 5, 3, 1},   // R2 high one short
    '{ 4, 6, 0, 0, 1},   // R5 gap exactly MIN_GAP
    '{ 3, 6, 0, 0, 0},   // R5 gap one short
    '{10, 0, 6, 0, 2},   // R3 fast edges
    '{10, 0, 3, 0, 0},   // R4 short high
    '{10, 2, 4, 2, 1},   // R2
    '{ 3, 0,10, 0, 0},   // R5 early high
    '{10, 0,20, 0, 2},   // R7 long high
    '{10,50, 0, 0, 1}    // R7 long mid
  };

  task automatic hold(input logic m, input logic h, input int n);
    aMid = m; aHigh = h;
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet during reset even with pin active
    @(negedge clk);
    hold(1'b1, 1'b1, 10);
    check("R1 mid in reset", int'(midEvt), 0);
    check("R1 high in reset", int'(highEvt), 0);
    hold(1'b0, 1'b0, 2);
    rst_n = 1'b1;
    midSeen = 0; highSeen = 0;
    hold(1'b0, 1'b0, TRAIL);
    check("R1 no strobe after reset", midSeen + highSeen, 0);

    for (int i = 0; i < NVEC; i++) begin
      midSeen = 0; highSeen = 0;
      hold(1'b0, 1'b0, VECS[i].low);
      hold(1'b1, 1'b0, VECS[i].rise);
      hold(1'b1, 1'b1, VECS[i].high);
      hold(1'b1, 1'b0, VECS[i].fall);
      if (midSeen + highSeen != 0) begin
        check($sformatf("R7 strobe while active vec%0d", i), midSeen + highSeen, 0);
      end
      hold(1'b0, 1'b0, TRAIL);
      check($sformatf("R2 mid count vec%0d", i), midSeen, (VECS[i].exp == 1) ? 1 : 0);
      check($sformatf("R3 high count vec%0d", i), highSeen, (VECS[i].exp == 2) ? 1 : 0);
    end

    // R6: exact latency and one-cycle width
    hold(1'b0, 1'b0, 12);
    hold(1'b1, 1'b0, 8);
    aMid = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R6 not before third edge", int'(midEvt), 0);
    @(negedge clk);
    check("R6 strobe on third edge", int'(midEvt), 1);
    @(negedge clk);
    check("R6 one cycle wide", int'(midEvt), 0);

    // R6 for a high pulse
    hold(1'b0, 1'b0, 12);
    hold(1'b1, 1'b1, 7);
    aMid = 1'b0; aHigh = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R6 high not early", int'(highEvt), 0);
    @(negedge clk);
    check("R6 high strobe", int'(highEvt), 1);
    check("R3 no mid with high", int'(midEvt), 0);
    @(negedge clk);
    check("R6 high one cycle", int'(highEvt), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule